// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Packer

This block takes an unsigned fixed-point magnitude, a sign bit and a run-time binary point position, and produces the matching IEEE-754 single-precision word. The binary point position says how many of the magnitude's low bits lie right of the point. The block finds the most significant set bit and turns its distance from the binary point into the exponent. It drops that bit as the implicit one. The bits below it are left-justified into the fraction field, and any bits that do not fit are truncated.

Words enter and leave through valid/ready handshakes. There are two register stages. The first registers the leading-one position. The second registers the shifted and packed word. With the output always ready, a result appears two cycles after its input is accepted. When the consumer stalls, the pipeline holds its contents and pushes back on the producer.

Top module: `fxp_to_f32_pack`

## Requirements
- R1: `out_word` carries the sign in bit 31, the biased exponent in bits 30..23 and the fraction in bits 22..0.
- R2: The sign bit of the result equals `in_sign` as given with the input (1 negative, 0 positive), including for a zero magnitude.
- R3: For a nonzero magnitude whose highest set bit is at position p, with binary point q, the exponent field is p - q + 127. With the default width this lies between 96 and 158.
- R4: The highest set bit is not stored. The fraction field holds the bits directly below it, most significant first, with zeros filled in below the last magnitude bit.
- R5: Magnitude bits more than 23 places below the highest set bit are discarded without rounding.
- R6: A zero magnitude gives an exponent field of 0 and a fraction field of 0.
- R7: `in_point` (0 to 31) is the count of fractional bits in `in_mag`. Raising it by one lowers the exponent by one and leaves the fraction unchanged.
- R8: While `out_ready` stays high, a word accepted at a clock edge appears on `out_valid`/`out_word` after exactly two edges, and back-to-back inputs come out back to back.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R10: When both stages hold data and the output is stalled, `in_ready` is low. No word is lost or duplicated, and order is kept.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_sign | input | 1 | Sign of the value, 1 negative |
| in_mag | input | 32 | Unsigned fixed-point magnitude |
| in_point | input | 5 | Number of fractional bits in in_mag |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result when high |
| out_word | output | 32 | Packed single-precision result |

## Verification
The embedded properties check the following on every cycle:
- Held output stays stable during a stall.
- `in_ready` is refused when the pipeline is full and stalled.
- Every accepted word enters the first stage.
- Every nonzero exponent stays inside the window that the width allows.
- A zero exponent always comes with a zero fraction.
- The detected leading position always points at the highest set bit.

Only the bench scenarios can show the exact packed values. These cover the worked examples, truncation of long magnitudes, the extreme binary point settings, sign handling for zero, the exact two-cycle latency and the in-order release of stalled words.

// File: rtl/fxp2f_pkg.sv
package fxp2f_pkg;
   localparam int F32_EXP_W  = 8;
   localparam int F32_FRAC_W = 23;
   localparam int F32_BIAS   = 127;
   localparam int F32_W      = 1 + F32_EXP_W + F32_FRAC_W;

   typedef struct packed {
      logic                  sign;
      logic [F32_EXP_W-1:0]  exp;
      logic [F32_FRAC_W-1:0] frac;
   } f32_word_t;
endpackage

// File: rtl/fxp2f_lead_one.sv
module fxp2f_lead_one #(
   parameter int W  = 32,
   localparam int PW = $clog2(W)
) (
   input  logic [W-1:0]  mag,
   output logic [PW-1:0] pos,
   output logic          zero
);
   logic [W:1]   above;
   logic [W-1:0] hit;

   assign above[W] = 1'b0;
   generate
      for (genvar i = W - 1; i >= 1; i--) begin : g_above
         assign above[i] = above[i+1] | mag[i];
      end
      for (genvar i = 0; i < W; i++) begin : g_hit
         assign hit[i] = mag[i] & ~above[i+1];
      end
   endgenerate

   always_comb begin
      pos = '0;
      for (int i = 0; i < W; i++) begin
         if (hit[i]) pos = pos | PW'(i);
      end
   end

   assign zero = ~(above[1] | mag[0]);

   // R4: the reported position is the highest set bit of a nonzero word
   always_comb begin
      if (!zero) begin
         p_lead_unique_r4: assert ((mag >> pos) == W'(1));
      end
   end
endmodule

// File: rtl/fxp2f_pack_stage.sv
module fxp2f_pack_stage
   import fxp2f_pkg::*;
#(
   parameter int W  = 32,
   localparam int PW    = $clog2(W),
   localparam int NW    = W + F32_FRAC_W,
   localparam int EXT_W = PW + F32_EXP_W + 2
) (
   input  logic          sign,
   input  logic [W-1:0]  mag,
   input  logic [PW-1:0] point,
   input  logic [PW-1:0] pos,
   input  logic          zero,
   output f32_word_t     word
);
   logic [PW-1:0] shamt;

   assign shamt = PW'(W - 1) - pos;

   always_comb begin
      word.sign = sign;
      if (zero) begin
         word.exp  = '0;
         word.frac = '0;
      end else begin
         word.exp  = F32_EXP_W'(EXT_W'(pos) + EXT_W'(F32_BIAS) - EXT_W'(point));
         word.frac = F32_FRAC_W'(({mag, {F32_FRAC_W{1'b0}}} << shamt) >> (W - 1));
      end
   end

   // R6: a zero word leaves exponent and fraction clear
   always_comb begin
      if (zero) begin
         p_zero_fields_r6: assert (word[F32_EXP_W+F32_FRAC_W-1:0] == '0);
      end
   end

   // keep NW referenced for width documentation
   localparam int NORM_BITS = NW;
endmodule

// File: rtl/fxp_to_f32_pack.sv
module fxp_to_f32_pack
   import fxp2f_pkg::*;
#(
   parameter int IN_W = 32,
   localparam int PW  = $clog2(IN_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic                in_sign,
   input  logic [IN_W-1:0]     in_mag,
   input  logic [PW-1:0]       in_point,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [F32_W-1:0]    out_word
);
   generate
      if (IN_W < 2 || IN_W > 128) begin : g_bad_width
         $error("IN_W must lie between 2 and 128");
      end
      if ((1 << PW) != IN_W) begin : g_bad_pow2
         $error("IN_W must be a power of two so in_point covers it exactly");
      end
   endgenerate

   logic [PW-1:0] lod_pos;
   logic          lod_zero;

   fxp2f_lead_one #(.W(IN_W)) u_lod (
      .mag  (in_mag),
      .pos  (lod_pos),
      .zero (lod_zero)
   );

   logic            s1_vld, s1_sign, s1_zero;
   logic [IN_W-1:0] s1_mag;
   logic [PW-1:0]   s1_point, s1_pos;
   logic            s1_ready;
   f32_word_t       packed_w;
   logic            out_vld_q;
   f32_word_t       out_q;

   assign s1_ready = ~out_vld_q | out_ready;
   assign in_ready = ~s1_vld | s1_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
      end else if (in_ready) begin
         s1_vld <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (in_ready && in_valid) begin
         s1_sign  <= in_sign;
         s1_mag   <= in_mag;
         s1_point <= in_point;
         s1_pos   <= lod_pos;
         s1_zero  <= lod_zero;
      end
   end

   fxp2f_pack_stage #(.W(IN_W)) u_pack (
      .sign  (s1_sign),
      .mag   (s1_mag),
      .point (s1_point),
      .pos   (s1_pos),
      .zero  (s1_zero),
      .word  (packed_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld_q <= 1'b0;
      end else if (s1_ready) begin
         out_vld_q <= s1_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (s1_ready && s1_vld) begin
         out_q <= packed_w;
      end
   end

   assign out_valid = out_vld_q;
   assign out_word  = out_q;

   // R9: a stalled result is held unchanged
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word));

   // R10: a full, stalled pipeline refuses new input
   p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && s1_vld |-> !in_ready);

   // R8: an accepted word always occupies the first stage next cycle
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> s1_vld);

   // R3: nonzero exponents stay in the window the width permits
   p_exp_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_word[30:23] != 8'd0 |->
         (int'(out_word[30:23]) >= F32_BIAS - (IN_W - 1)) &&
         (int'(out_word[30:23]) <= F32_BIAS + (IN_W - 1)));

   // R6: zero exponent comes with zero fraction at the port
   p_zero_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_word[30:23] == 8'd0 |-> out_word[22:0] == 23'd0);
endmodule

// File: tb/fxp_to_f32_pack_test.sv
module fxp_to_f32_pack_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_sign = 1'b0;
   logic [31:0] in_mag = '0;
   logic [4:0]  in_point = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_word;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   fxp_to_f32_pack uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sign(in_sign), .in_mag(in_mag), .in_point(in_point),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
   );

   function automatic logic [31:0] ref_pack(input logic s, input logic [31:0] m, input int q);
      int msb = -1;
      logic [22:0] f = '0;
      logic [7:0] e;
      for (int i = 0; i < 32; i++) if (m[i]) msb = i;
      if (msb < 0) return {s, 31'd0};
      e = 8'(msb - q + 127);
      for (int k = 1; k <= 23; k++) f[23-k] = (msb - k >= 0) ? m[msb-k] : 1'b0;
      return {s, e, f};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one word, expect it after exactly two edges
   task automatic one_word(input logic s, input logic [31:0] m, input logic [4:0] q,
                           input logic [31:0] exp, input string req);
      @(negedge clk);
      out_ready = 1'b1;
      in_valid = 1'b1; in_sign = s; in_mag = m; in_point = q;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b0, "R8 early", {31'd0, out_valid}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b1, "R8 latency", {31'd0, out_valid}, 32'd1);
      check(out_word == exp, req, out_word, exp);
      @(posedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(out_valid == 1'b0, "R11 out_valid", {31'd0, out_valid}, 32'd0);
      check(in_ready == 1'b1, "R11 in_ready", {31'd0, in_ready}, 32'd1);
   endtask

   task automatic t_examples();
      // R1 R4: 1101.101 with 3 fractional bits
      one_word(1'b0, 32'h6D, 5'd3, 32'h415A0000, "R1 R4 positive example");
      // R2 R3: -0.00101 with 5 fractional bits
      one_word(1'b1, 32'h5, 5'd5, 32'hBE200000, "R2 R3 negative example");
   endtask

   task automatic t_truncate();
      // R5: all ones, no rounding up
      one_word(1'b0, 32'hFFFFFFFF, 5'd0, 32'h4F7FFFFF, "R5 all ones");
      // R5: 0.2 in 31 fractional bits
      one_word(1'b0, 32'h19999999, 5'd31, ref_pack(1'b0, 32'h19999999, 31), "R5 point two");
   endtask

   task automatic t_zero();
      one_word(1'b1, 32'h0, 5'd7, 32'h80000000, "R6 negative zero");
      one_word(1'b0, 32'h0, 5'd0, 32'h00000000, "R6 R2 positive zero");
   endtask

   task automatic t_point();
      // R7: smallest and largest exponent, plus one-step change
      one_word(1'b0, 32'h1, 5'd31, 32'h30000000, "R7 min exponent");
      one_word(1'b0, 32'h80000000, 5'd0, 32'h4F000000, "R7 max exponent");
      one_word(1'b1, 32'h00ABCDEF, 5'd10, ref_pack(1'b1, 32'h00ABCDEF, 10), "R7 point 10");
      one_word(1'b1, 32'h00ABCDEF, 5'd11, ref_pack(1'b1, 32'h00ABCDEF, 11), "R7 point 11");
   endtask

   task automatic t_stream();
      // R8: back-to-back words emerge on consecutive cycles
      logic [31:0] m0 = 32'h12345678, m1 = 32'h00000300, m2 = 32'h7;
      @(negedge clk);
      out_ready = 1'b1;
      in_valid = 1'b1; in_sign = 0; in_mag = m0; in_point = 5'd16;
      @(negedge clk); in_mag = m1; in_point = 5'd4;
      @(negedge clk); in_mag = m2; in_point = 5'd2; in_sign = 1;
      check(out_valid && out_word == ref_pack(0, m0, 16), "R8 stream 0", out_word, ref_pack(0, m0, 16));
      @(negedge clk); in_valid = 0;
      check(out_valid && out_word == ref_pack(0, m1, 4), "R8 stream 1", out_word, ref_pack(0, m1, 4));
      @(negedge clk);
      check(out_valid && out_word == ref_pack(1, m2, 2), "R8 stream 2", out_word, ref_pack(1, m2, 2));
      @(negedge clk);
      check(!out_valid, "R8 drained", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic t_stall();
      logic [31:0] ea = ref_pack(0, 32'h00F00000, 8);
      logic [31:0] eb = ref_pack(1, 32'h00000013, 1);
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1; in_sign = 0; in_mag = 32'h00F00000; in_point = 5'd8;
      @(negedge clk);
      in_sign = 1; in_mag = 32'h00000013; in_point = 5'd1;
      @(negedge clk);
      in_valid = 0;
      check(in_ready == 1'b0, "R10 full refuses", {31'd0, in_ready}, 32'd0);
      for (int i = 0; i < 4; i++) @(negedge clk);
      check(out_valid && out_word == ea, "R9 held word", out_word, ea);
      check(in_ready == 1'b0, "R10 still full", {31'd0, in_ready}, 32'd0);
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid && out_word == eb, "R10 order kept", out_word, eb);
      @(negedge clk);
      check(!out_valid, "R10 no duplicate", {31'd0, out_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_examples();
      t_truncate();
      t_zero();
      t_point();
      t_stream();
      t_stall();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule